// File: doc/BRIEF.md
# USB PD Message Transmit Sequencer

This block drives the transmit side of a USB Power Delivery protocol layer that sits on the manager side of a port-controller register interface. When the policy engine asks for a message, the sequencer copies the payload bytes into the controller's transmit register window, one register write per cycle. It then writes a transmit command that carries the current 3-bit MessageID.

After the command, the sequencer waits for one of three controller alerts: success, failure or discard. A retransmit timer of one millisecond, counted in clock cycles, covers a controller that raises no alert. Failures and timeouts re-issue the command. The payload is not rewritten on a retry, because it is still held in the window. After the allowed number of retries, the policy engine gets an error report.

A soft-reset request or a fast-role-swap event aborts any transfer in progress and zeroes the MessageID.

Top module: `pd_tx_sequencer`

## Requirements
- R1: After reset the block is idle: `busy`, `wr_en`, all report pulses and all clear pulses are low, and `msg_id` is 0.
- R2: A request of length L writes payload byte k to address 0x41+k with data `pay_byte` (with `pay_idx`=k), for k = 0..L-1, one per cycle in rising order. It then writes the command address (default 0x3C) with data {5'b0, MessageID}.
- R3: A success alert produces a one-cycle `pe_sent` and `clr_ok` and increments the MessageID modulo 8. Eight successes return it to its starting value.
- R4: A failure alert pulses `clr_fail` and re-issues only the command write. The payload is not rewritten. When MAX_RETRY+1 commands have all failed, `pe_err` pulses once and the MessageID is unchanged.
- R5: If no alert arrives within CLK_KHZ cycles after a command, the attempt counts as a failure without `clr_fail`. Consecutive command writes are then CLK_KHZ+1 cycles apart.
- R6: A discard alert pulses `pe_disc` and `clr_disc`, increments the MessageID, and ends the transfer with no further command.
- R7: `soft_rst_req` in any state abandons the transfer without any report and sets the MessageID to 0 on the next cycle.
- R8: `frs_evt` has the same effect as R7.
- R9: `req_valid` while `busy` is high is ignored. No extra payload or command writes follow.
- R10: A length of 0 produces no payload write and only a command write. A length above 31 is clamped to 31 writes, the last at 0x5F.
- R11: When several alerts arrive in the same cycle, discard wins over failure and failure wins over success.
- R12: The retry count starts from zero for each new message, so a message after an error again gets MAX_RETRY+1 attempts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Policy-engine message request pulse |
| req_len | input | 6 | Payload length in bytes |
| soft_rst_req | input | 1 | Soft-reset request from policy engine |
| frs_evt | input | 1 | Fast-role-swap signal sent or detected |
| pay_idx | output | 5 | Index of payload byte being fetched |
| pay_byte | input | 8 | Payload byte at `pay_idx` |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 8 | Register write address |
| wr_data | output | 8 | Register write data |
| alert_ok | input | 1 | Controller transmit-success alert |
| alert_fail | input | 1 | Controller transmit-failed alert |
| alert_disc | input | 1 | Controller transmit-discarded alert |
| clr_ok | output | 1 | Clear success alert |
| clr_fail | output | 1 | Clear failed alert |
| clr_disc | output | 1 | Clear discarded alert |
| pe_sent | output | 1 | Message sent report |
| pe_err | output | 1 | Transmission error report |
| pe_disc | output | 1 | Message discarded report |
| busy | output | 1 | Transfer in progress |
| msg_id | output | 3 | Current MessageID |

## Verification
The bench targets the retry boundary, where an off-by-one would report the error after two or four commands instead of three. It also targets a timer one cycle short or long, which moves the gap between command writes away from CLK_KHZ+1.

Simultaneous alerts are driven to catch a wrong priority, which would report success on a failed or discarded frame. Length 0 and an oversized length catch a window overrun past 0x5F and a spurious first write.

Resets arriving mid-payload or mid-wait catch a sequencer that still issues the command or keeps a stale MessageID. Eight back-to-back successes expose a counter that does not wrap.

// File: rtl/pd_tx_sequencer.sv
module pd_tx_sequencer #(
  parameter int          CLK_KHZ   = 100000,
  parameter int          MAX_RETRY = 2,
  parameter int          PAY_SLOTS = 31,
  parameter logic [7:0]  PAY_BASE  = 8'h41,
  parameter logic [7:0]  CMD_ADDR  = 8'h3C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [5:0] req_len,
  input  logic       soft_rst_req,
  input  logic       frs_evt,
  output logic [4:0] pay_idx,
  input  logic [7:0] pay_byte,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  input  logic       alert_ok,
  input  logic       alert_fail,
  input  logic       alert_disc,
  output logic       clr_ok,
  output logic       clr_fail,
  output logic       clr_disc,
  output logic       pe_sent,
  output logic       pe_err,
  output logic       pe_disc,
  output logic       busy,
  output logic [2:0] msg_id
);
  localparam int TMO = (CLK_KHZ < 1) ? 1 : CLK_KHZ;
  localparam int TW  = $clog2(TMO + 1);
  localparam int RW  = $clog2(MAX_RETRY + 2);
  localparam logic [TW-1:0] TMO_LAST = TW'(TMO - 1);
  localparam logic [RW-1:0] RMAX     = RW'(MAX_RETRY);
  localparam logic [5:0]    SLOTS    = 6'(PAY_SLOTS);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_CMD, S_WAIT, S_LRST} st_t;

  st_t           st;
  logic [5:0]    len;
  logic [4:0]    idx;
  logic [RW-1:0] retry;
  logic [TW-1:0] tmr;
  logic [2:0]    id;

  assign wr_en   = (st == S_LOAD) || (st == S_CMD);
  assign wr_addr = (st == S_CMD) ? CMD_ADDR : PAY_BASE + 8'(idx);
  assign wr_data = (st == S_CMD) ? {5'b0, id} : pay_byte;
  assign pay_idx = idx;
  assign busy    = (st != S_IDLE);
  assign msg_id  = id;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;  len <= '0;  idx <= '0;  retry <= '0;  tmr <= '0;  id <= '0;
      clr_ok <= 1'b0;  clr_fail <= 1'b0;  clr_disc <= 1'b0;
      pe_sent <= 1'b0; pe_err <= 1'b0;    pe_disc <= 1'b0;
    end else begin
      clr_ok <= 1'b0;  clr_fail <= 1'b0;  clr_disc <= 1'b0;
      pe_sent <= 1'b0; pe_err <= 1'b0;    pe_disc <= 1'b0;
      if (soft_rst_req || frs_evt) begin
        st <= S_LRST;  id <= '0;  retry <= '0;  idx <= '0;
      end else begin
        case (st)
          S_IDLE: if (req_valid) begin
            len   <= (req_len > SLOTS) ? SLOTS : req_len;
            idx   <= '0;
            retry <= '0;
            st    <= (req_len == 6'd0) ? S_CMD : S_LOAD;
          end
          S_LOAD: begin
            if ({1'b0, idx} == len - 6'd1) begin
              idx <= '0;
              st  <= S_CMD;
            end else
              idx <= idx + 5'd1;
          end
          S_CMD: begin
            tmr <= TMO_LAST;
            st  <= S_WAIT;
          end
          S_WAIT: begin
            if (alert_disc) begin
              clr_disc <= 1'b1;  pe_disc <= 1'b1;  id <= id + 3'd1;  st <= S_IDLE;
            end else if (alert_fail || (!alert_ok && tmr == '0)) begin
              clr_fail <= alert_fail;
              if (retry == RMAX) begin
                pe_err <= 1'b1;
                st     <= S_IDLE;
              end else begin
                retry <= retry + 1'b1;
                st    <= S_CMD;
              end
            end else if (alert_ok) begin
              clr_ok <= 1'b1;  pe_sent <= 1'b1;  id <= id + 3'd1;  st <= S_IDLE;
            end else
              tmr <= tmr - 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R2
  payload_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != CMD_ADDR) |->
      (wr_addr >= PAY_BASE && 32'(wr_addr) < 32'(PAY_BASE) + PAY_SLOTS));
  // R3
  sent_bumps_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pe_sent |-> msg_id == $past(msg_id) + 3'd1);
  // R3
  sent_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ok |-> pe_sent);
  // R4
  retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry <= RMAX);
  // R7
  softrst_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_req |=> msg_id == 3'd0);
  // R11
  one_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pe_sent, pe_err, pe_disc}));
endmodule

// File: tb/test_pd_tx_sequencer.sv
module test_pd_tx_sequencer;
  localparam int KHZ = 8;
  localparam int NR  = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, req_valid = 1'b0, soft_rst_req = 1'b0, frs_evt = 1'b0;
  logic alert_ok = 1'b0, alert_fail = 1'b0, alert_disc = 1'b0;
  logic [5:0] req_len = '0;
  logic [4:0] pay_idx;
  logic [7:0] pay_byte, wr_addr, wr_data;
  logic wr_en, clr_ok, clr_fail, clr_disc, pe_sent, pe_err, pe_disc, busy;
  logic [2:0] msg_id;

  assign pay_byte = 8'hA5 ^ {3'b0, pay_idx};

  pd_tx_sequencer #(.CLK_KHZ(KHZ), .MAX_RETRY(NR)) i_pd_tx_sequencer (
    .clk, .rst_n, .req_valid, .req_len, .soft_rst_req, .frs_evt, .pay_idx, .pay_byte,
    .wr_en, .wr_addr, .wr_data, .alert_ok, .alert_fail, .alert_disc,
    .clr_ok, .clr_fail, .clr_disc, .pe_sent, .pe_err, .pe_disc, .busy, .msg_id);

  int total = 0, bad = 0, cyc = 0;
  int pw_cnt, cmd_cnt, sent_n, err_n, disc_n, cok_n, cfail_n, cdisc_n, last_cmd, gap;
  logic [7:0] cmd_data, last_pay;
  logic [2:0] exp_id = 3'd0;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  always @(negedge clk) if (rst_n) begin
    if (wr_en) begin
      if (wr_addr == 8'h3C) begin
        cmd_cnt++;  cmd_data = wr_data;  gap = cyc - last_cmd;  last_cmd = cyc;
      end else begin
        chk(int'(wr_addr) == 8'h41 + pw_cnt, "R2 payload address", int'(wr_addr), 8'h41 + pw_cnt);
        chk(wr_data == (8'hA5 ^ 8'(pw_cnt)), "R2 payload data", int'(wr_data), int'(8'hA5 ^ 8'(pw_cnt)));
        last_pay = wr_addr;
        pw_cnt++;
      end
    end
    if (pe_sent)  sent_n++;
    if (pe_err)   err_n++;
    if (pe_disc)  disc_n++;
    if (clr_ok)   cok_n++;
    if (clr_fail) cfail_n++;
    if (clr_disc) cdisc_n++;
  end

  task automatic clear();
    pw_cnt = 0; cmd_cnt = 0; sent_n = 0; err_n = 0; disc_n = 0;
    cok_n = 0; cfail_n = 0; cdisc_n = 0; gap = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(int len);
    @(negedge clk); req_valid = 1'b1; req_len = 6'(len);
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic wait_cmd(int k);
    wait (cmd_cnt >= k);
  endtask

  task automatic alert(bit ok, bit fl, bit ds);
    @(negedge clk); alert_ok = ok; alert_fail = fl; alert_disc = ds;
    @(negedge clk); alert_ok = 1'b0; alert_fail = 1'b0; alert_disc = 1'b0;
  endtask

  task automatic t_reset();
    chk(!busy && !wr_en, "R1 idle after reset", int'({busy, wr_en}), 0);
    chk(msg_id == 3'd0, "R1 msg_id after reset", int'(msg_id), 0);
    chk(!(pe_sent | pe_err | pe_disc | clr_ok | clr_fail | clr_disc), "R1 pulses low", 1, 0);
  endtask

  task automatic t_success(int len, string req);
    int n = (len > 31) ? 31 : len;
    clear();
    send(len); wait_cmd(1); alert(1, 0, 0); idle(3);
    chk(pw_cnt == n, {req, " payload count"}, pw_cnt, n);
    chk(cmd_cnt == 1, "R2 one command", cmd_cnt, 1);
    chk(cmd_data == {5'b0, exp_id}, "R2 command carries id", int'(cmd_data), int'(exp_id));
    chk(sent_n == 1 && cok_n == 1, "R3 sent and cleared", sent_n + cok_n, 2);
    exp_id = exp_id + 3'd1;
    chk(msg_id == exp_id, "R3 id incremented", int'(msg_id), int'(exp_id));
  endtask

  task automatic t_wrap();
    logic [2:0] start = exp_id;
    for (int i = 0; i < 8; i++) t_success(2, "R3");
    chk(msg_id == start, "R3 id wraps after eight", int'(msg_id), int'(start));
  endtask

  task automatic t_fail_all(string req);
    clear();
    send(3);
    for (int a = 1; a <= NR + 1; a++) begin
      wait_cmd(a); alert(0, 1, 0);
    end
    idle(3);
    chk(cmd_cnt == NR + 1, {req, " attempts before error"}, cmd_cnt, NR + 1);
    chk(pw_cnt == 3, "R4 payload written once", pw_cnt, 3);
    chk(err_n == 1 && cfail_n == NR + 1, "R4 error and clears", err_n * 10 + cfail_n, 10 + NR + 1);
    chk(sent_n == 0 && msg_id == exp_id, "R4 id unchanged", int'(msg_id), int'(exp_id));
  endtask

  task automatic t_timeout();
    clear();
    send(2); wait (err_n == 1); idle(2);
    chk(cmd_cnt == NR + 1, "R5 timeout retries", cmd_cnt, NR + 1);
    chk(gap == KHZ + 1, "R5 command spacing", gap, KHZ + 1);
    chk(cfail_n == 0 && pw_cnt == 2, "R5 no clear on timeout", cfail_n, 0);
  endtask

  task automatic t_discard();
    clear();
    send(4); wait_cmd(1); alert(0, 0, 1); idle(KHZ * 3);
    chk(disc_n == 1 && cdisc_n == 1, "R6 discard reported", disc_n + cdisc_n, 2);
    chk(cmd_cnt == 1 && err_n == 0, "R6 no further command", cmd_cnt, 1);
    exp_id = exp_id + 3'd1;
    chk(msg_id == exp_id, "R6 id incremented", int'(msg_id), int'(exp_id));
  endtask

  task automatic t_priority();
    clear();
    send(1); wait_cmd(1); alert(1, 1, 0); wait_cmd(2);
    chk(sent_n == 0 && cfail_n == 1, "R11 fail beats ok", sent_n, 0);
    alert(1, 0, 1); idle(3);
    chk(disc_n == 1 && sent_n == 0, "R11 discard beats ok", disc_n, 1);
    exp_id = exp_id + 3'd1;
    chk(msg_id == exp_id, "R11 id after discard", int'(msg_id), int'(exp_id));
  endtask

  task automatic t_busy();
    clear();
    send(10); send(5); wait_cmd(1); alert(1, 0, 0); idle(KHZ * 2);
    chk(pw_cnt == 10 && cmd_cnt == 1, "R9 request while busy ignored", pw_cnt, 10);
    chk(sent_n == 1, "R9 single report", sent_n, 1);
    exp_id = exp_id + 3'd1;
  endtask

  task automatic t_len_edges();
    t_success(0, "R10 zero length");
    t_success(40, "R10 clamp");
    chk(last_pay == 8'h5F, "R10 last address", int'(last_pay), 8'h5F);
  endtask

  task automatic t_softrst();
    clear();
    send(20); idle(3);
    @(negedge clk); soft_rst_req = 1'b1; @(negedge clk); soft_rst_req = 1'b0;
    idle(KHZ * 3);
    chk(cmd_cnt == 0 && pw_cnt < 20, "R7 transfer abandoned", cmd_cnt, 0);
    chk(sent_n + err_n + disc_n == 0, "R7 no report", sent_n + err_n + disc_n, 0);
    chk(msg_id == 3'd0, "R7 id zeroed", int'(msg_id), 0);
    exp_id = 3'd0;
  endtask

  task automatic t_frs();
    t_success(1, "R2");
    clear();
    send(2); wait_cmd(1); idle(2);
    @(negedge clk); frs_evt = 1'b1; @(negedge clk); frs_evt = 1'b0;
    idle(KHZ * 3);
    chk(cmd_cnt == 1 && err_n == 0, "R8 wait abandoned", cmd_cnt * 10 + err_n, 10);
    chk(msg_id == 3'd0 && !busy, "R8 id zeroed", int'(msg_id), 0);
    exp_id = 3'd0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clear();
    last_cmd = 0;
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_success(5, "R2");
    t_wrap();
    t_fail_all("R4");
    t_fail_all("R12");
    t_timeout();
    t_discard();
    t_priority();
    t_busy();
    t_len_edges();
    t_softrst();
    t_success(2, "R7 restart");
    t_frs();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule